// File: doc/BRIEF.md
# Receiver Clock Recovery Lock-Mode Controller

This block decides whether a receiver's clock recovery loop follows the local reference clock or the incoming serial data. It also drives a frequency-locked status flag. The loop can be steered in two ways. Two manual override requests let system logic force either tracking mode. With neither request asserted, an automatic mode takes over. In automatic mode, data tracking is chosen only while the frequency detector and the phase detector both report good conditions. The analog loop itself and both detectors sit outside this block and appear here only as input signals.

A typical manual bring-up holds the reference-tracking request first so that the loop trains on the reference clock. Some time later it raises the data-tracking request. The data request has priority over the reference request. Once data tracking has been forced, the locked flag stays high until an analog reset clears it. It does not matter which mode follows. The analog reset is synchronous and active high. It behaves like a power-down: it overrides every request and returns the block to reference tracking with the flag low.

Both outputs are registered. A change at the inputs sampled on one rising clock edge appears at the outputs right after that edge.

Top module: `cdr_lock_mode_ctrl`

## Requirements
- R1: While `rst_n` is sampled low, both outputs are 0 after the edge (`track_data` 0 means reference tracking, 1 means data tracking).
- R2: When `lock_data_req` and `lock_ref_req` are both sampled high and `ana_rst` is low, `track_data` is 1 after the edge.
- R3: When `lock_data_req` is sampled high and `ana_rst` is low, `track_data` and `freq_locked` are both 1 after the edge, whatever the detector inputs are.
- R4: In automatic mode (no request, no analog reset), `track_data` and `freq_locked` become 1 after an edge at which `freq_in_ppm` and `phase_ready` are both sampled high; `track_data` is never 1 while `freq_locked` is 0.
- R5: In automatic mode, an edge at which either detector input is sampled low gives `track_data` 0, and also gives `freq_locked` 0 unless R7 holds it.
- R6: When `lock_ref_req` alone is sampled high (no data request, no analog reset), `track_data` is 0 and `freq_locked` keeps its previous value, however the detector inputs toggle.
- R7: After a manual data request ends, `freq_locked` stays 1 in both automatic and manual reference modes until `ana_rst` is sampled high.
- R8: When `ana_rst` is sampled high, both outputs are 0 after the edge, overriding both requests, and the hold of R7 is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| ana_rst | input | 1 | Synchronous active-high analog reset (power-down) |
| lock_ref_req | input | 1 | Manual request to track the reference clock |
| lock_data_req | input | 1 | Manual request to track incoming data (wins over `lock_ref_req`) |
| freq_in_ppm | input | 1 | Frequency detector reports frequency within threshold |
| phase_ready | input | 1 | Phase-relationship detector reports ready |
| track_data | output | 1 | Mode select: 0 reference tracking, 1 data tracking |
| freq_locked | output | 1 | Frequency-locked status flag |

## Verification
The hidden state of this block is the hold bit that keeps the locked flag high after a manual data request. A wrong value of that bit does not show while a data request is active, because the request drives the flag high on its own. It shows on the first edge after the request ends with the detectors low: the flag drops when it should stay high, or stays high after an analog reset when it should drop. The bench therefore leaves manual data mode with the detectors deliberately low. It then toggles the detectors under a reference request to expose a wrongly held or wrongly updated flag within one cycle.

// File: rtl/cdr_lock_pkg.sv
// Package: cdr_lock_pkg
// Holds the control-source encoding that the arbiter hands to the
// mode and flag registers. It assumes one source is active per cycle.
package cdr_lock_pkg;
    typedef enum logic [1:0] {
        SRC_AUTO     = 2'd0,
        SRC_MAN_REF  = 2'd1,
        SRC_MAN_DATA = 2'd2,
        SRC_PWRDN    = 2'd3
    } lock_src_e;
endpackage

// File: rtl/lock_src_arb.sv
// Module: lock_src_arb
// Fixed-priority selection of the control source for this cycle:
// analog reset, then the data request, then the reference request,
// then automatic mode. Purely combinational; inputs are assumed to be
// synchronous to the controller clock.
module lock_src_arb
    import cdr_lock_pkg::*;
(
    input  logic      ana_rst,
    input  logic      lock_ref_req,
    input  logic      lock_data_req,
    output lock_src_e src
);
    // Priority decode of the three control inputs
    always_comb begin
        if (ana_rst)            src = SRC_PWRDN;
        else if (lock_data_req) src = SRC_MAN_DATA;
        else if (lock_ref_req)  src = SRC_MAN_REF;
        else                    src = SRC_AUTO;
    end
endmodule

// File: rtl/track_sel_reg.sv
// Module: track_sel_reg
// Registers the tracking-mode select. Automatic mode picks data
// tracking only when both detector conditions hold in the sampled
// cycle. Assumes a synchronous active-low system reset.
module track_sel_reg
    import cdr_lock_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lock_src_e src,
    input  logic      both_ok,
    output logic      track_data
);
    // Next tracking mode from the selected source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            track_data <= 1'b0;
        end else begin
            case (src)
                SRC_PWRDN:    track_data <= 1'b0;
                SRC_MAN_DATA: track_data <= 1'b1;
                SRC_MAN_REF:  track_data <= 1'b0;
                default:      track_data <= both_ok;
            endcase
        end
    end

    // R2
    data_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_MAN_DATA) |=> track_data);
    // R8
    pwrdn_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_PWRDN) |=> !track_data);
    // R6
    man_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_MAN_REF) |=> !track_data);
endmodule

// File: rtl/lock_flag_reg.sv
// Module: lock_flag_reg
// Registers the frequency-locked flag and the hold bit that keeps
// it high after manual data tracking until an analog reset. Assumes
// a synchronous active-low system reset.
module lock_flag_reg
    import cdr_lock_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lock_src_e src,
    input  logic      both_ok,
    output logic      freq_locked
);
    logic hold_hi;

    // Hold bit: set by manual data tracking, cleared by analog reset
    always_ff @(posedge clk) begin
        if (!rst_n)                    hold_hi <= 1'b0;
        else if (src == SRC_PWRDN)     hold_hi <= 1'b0;
        else if (src == SRC_MAN_DATA)  hold_hi <= 1'b1;
    end

    // Locked flag update for each control source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_locked <= 1'b0;
        end else begin
            case (src)
                SRC_PWRDN:    freq_locked <= 1'b0;
                SRC_MAN_DATA: freq_locked <= 1'b1;
                SRC_MAN_REF:  freq_locked <= freq_locked;
                default:      freq_locked <= hold_hi | both_ok;
            endcase
        end
    end

    // R6
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_MAN_REF) |=> $stable(freq_locked));
    // R3
    data_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_MAN_DATA) |=> freq_locked);
    // R8
    pwrdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_PWRDN) |=> !freq_locked);
    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_locked && hold_hi && src != SRC_PWRDN) |=> freq_locked);
endmodule

// File: rtl/cdr_lock_mode_ctrl.sv
// Module: cdr_lock_mode_ctrl
// Top of the clock recovery lock-mode controller. Arbitrates the
// manual requests against automatic mode and registers the mode
// select and locked flag. Assumes all inputs are synchronous to clk.
module cdr_lock_mode_ctrl
    import cdr_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ana_rst,
    input  logic lock_ref_req,
    input  logic lock_data_req,
    input  logic freq_in_ppm,
    input  logic phase_ready,
    output logic track_data,
    output logic freq_locked
);
    lock_src_e src;
    logic      both_ok;

    // Both detector conditions in the same sampled cycle
    assign both_ok = freq_in_ppm & phase_ready;

    lock_src_arb u_arb (
        .ana_rst       (ana_rst),
        .lock_ref_req  (lock_ref_req),
        .lock_data_req (lock_data_req),
        .src           (src)
    );

    track_sel_reg u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (src),
        .both_ok    (both_ok),
        .track_data (track_data)
    );

    lock_flag_reg u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .src         (src),
        .both_ok     (both_ok),
        .freq_locked (freq_locked)
    );

    // R4
    track_implies_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        track_data |-> freq_locked);
    // R5
    auto_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ana_rst && !lock_ref_req && !lock_data_req && !(freq_in_ppm && phase_ready))
        |=> !track_data);
endmodule

// File: tb/tb_cdr_lock_mode_ctrl.sv
module tb_cdr_lock_mode_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ana_rst = 1'b0;
    logic lock_ref_req = 1'b0;
    logic lock_data_req = 1'b0;
    logic freq_in_ppm = 1'b0;
    logic phase_ready = 1'b0;
    logic track_data;
    logic freq_locked;

    typedef struct {
        logic  trk;
        logic  lck;
        string tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    logic m_trk = 1'b0;
    logic m_lck = 1'b0;
    logic m_hold = 1'b0;

    always #10 clk = ~clk;

    cdr_lock_mode_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ana_rst       (ana_rst),
        .lock_ref_req  (lock_ref_req),
        .lock_data_req (lock_data_req),
        .freq_in_ppm   (freq_in_ppm),
        .phase_ready   (phase_ready),
        .track_data    (track_data),
        .freq_locked   (freq_locked)
    );

    // Driver: apply one cycle of inputs and push the expected result
    task automatic drive(input logic rn, input logic ar, input logic rr,
                         input logic dr, input logic fo, input logic po,
                         input string tag);
        exp_item_t it;
        @(negedge clk);
        rst_n = rn; ana_rst = ar; lock_ref_req = rr;
        lock_data_req = dr; freq_in_ppm = fo; phase_ready = po;
        if (!rn || ar) begin
            m_trk = 1'b0; m_lck = 1'b0; m_hold = 1'b0;
        end else if (dr) begin
            m_trk = 1'b1; m_lck = 1'b1; m_hold = 1'b1;
        end else if (rr) begin
            m_trk = 1'b0;
        end else begin
            m_trk = fo & po;
            m_lck = m_hold | (fo & po);
        end
        it.trk = m_trk; it.lck = m_lck; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: compare outputs just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_item_t it;
                it = exp_q.pop_front();
                n_checks += 2;
                if (track_data !== it.trk) begin
                    n_fail++;
                    $display("FAIL %s track_data actual=%b expected=%b", it.tag, track_data, it.trk);
                end
                if (freq_locked !== it.lck) begin
                    n_fail++;
                    $display("FAIL %s freq_locked actual=%b expected=%b", it.tag, freq_locked, it.lck);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 5000);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        drive(0, 0, 0, 0, 1, 1, "R1");
        drive(0, 0, 0, 1, 1, 1, "R1");
        // R4 auto: one detector alone is not enough
        drive(1, 0, 0, 0, 1, 0, "R4");
        drive(1, 0, 0, 0, 0, 1, "R4");
        drive(1, 0, 0, 0, 1, 1, "R4");
        drive(1, 0, 0, 0, 1, 1, "R4");
        // R5 losing a condition returns to reference
        drive(1, 0, 0, 0, 1, 0, "R5");
        drive(1, 0, 0, 0, 1, 1, "R5");
        drive(1, 0, 0, 0, 0, 1, "R5");
        // R8 analog reset in auto with detectors good
        drive(1, 0, 0, 0, 1, 1, "R8");
        drive(1, 1, 0, 0, 1, 1, "R8");
        // R6 manual ref from flag low, detectors toggling
        drive(1, 0, 1, 0, 1, 1, "R6");
        drive(1, 0, 1, 0, 0, 0, "R6");
        drive(1, 0, 1, 0, 1, 1, "R6");
        // R3 manual data with detectors low
        drive(1, 0, 0, 1, 0, 0, "R3");
        // R2 both requests: data wins
        drive(1, 0, 1, 1, 0, 0, "R2");
        // R6 and R7 manual ref after data: flag held high
        drive(1, 0, 1, 0, 0, 0, "R7");
        drive(1, 0, 1, 0, 1, 1, "R6");
        // R7 auto after data with detectors low: flag still high
        drive(1, 0, 0, 0, 0, 0, "R7");
        drive(1, 0, 0, 0, 1, 1, "R7");
        drive(1, 0, 0, 0, 0, 1, "R7");
        // R8 analog reset clears the hold
        drive(1, 1, 0, 0, 0, 0, "R8");
        drive(1, 0, 0, 0, 0, 0, "R8");
        // R8 analog reset overrides both requests
        drive(1, 0, 0, 1, 0, 0, "R3");
        drive(1, 1, 1, 1, 1, 1, "R8");
        drive(1, 0, 1, 0, 0, 0, "R8");
        // Typical sequence: train on reference, then data
        drive(1, 0, 1, 0, 0, 0, "R6");
        drive(1, 0, 1, 0, 0, 0, "R6");
        drive(1, 0, 1, 1, 0, 0, "R2");
        drive(1, 0, 0, 1, 0, 0, "R3");
        // R1 system reset mid-run clears everything
        drive(0, 0, 0, 1, 1, 1, "R1");
        drive(1, 0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule